// File: doc/BRIEF.md
# Sixteen-Entry Working Register Bank with Stack-Pointer Entry

This block is the general-purpose register bank of a small 16-bit processor core. It holds sixteen 16-bit registers. Any of them may hold data, an address or an offset. Two combinational read ports and one registered write port serve the datapath. The write port can replace a whole word, or it can replace only the low byte and leave the upper byte as it was.

The last entry is the stack pointer. It is always word-aligned and has its own non-zero reset value. It also has a dedicated adjust port that moves it by two for push and pop, and this port overrides a normal write to the same entry. The entry before it is an ordinary register that software uses by convention as a frame pointer.

A 4-bit default-register select names the entry that file-register style operations use as their implicit operand, and that entry's value is presented on its own output. A separate word-aligned stack-limit register completes the block. Shadow copies, instruction decode and memory-mapped access are handled elsewhere.

Top module: `gpr_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising clock edge), every register reads 0x0000 except register 15, which reads 0x0200. The default select reads 0 and the stack-limit register reads 0x0000.
- R2: A word write (wr_en=1, wr_byte=0) stores all 16 bits of wr_data into register wr_sel, and the new value is visible on both read ports from the next cycle on. Registers that are not addressed keep their values.
- R3: A byte write (wr_en=1, wr_byte=1) replaces bits 7:0 of the addressed register with wr_data[7:0] and leaves bits 15:8 unchanged.
- R4: Reads are combinational. When a read port selects the register being written in the same cycle, it returns the value from before the write.
- R5: Bit 0 of register 15 always reads as zero, after both word writes and byte writes of an odd value.
- R6: When sp_adj_en is 1, register 15 becomes its old value plus 2 if sp_adj_up is 1, or minus 2 if sp_adj_up is 0. The arithmetic wraps modulo 2^16.
- R7: If sp_adj_en is 1 and a normal write targets register 15 in the same cycle, only the adjustment takes effect. A normal write to any other register in that cycle still takes effect.
- R8: A write with dflt_wr_en=1 loads dflt_wr_sel into the default select from the next cycle on. dflt_data always shows the current value of the register named by dflt_sel.
- R9: A write with lim_wr_en=1 loads lim_wr_data into the stack-limit register with bit 0 forced to zero. Normal writes and stack adjustments leave the limit unchanged.
- R10: sp_out always equals the current value of register 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_sel | input | 4 | Read port A register index |
| rd_a_data | output | 16 | Read port A value |
| rd_b_sel | input | 4 | Read port B register index |
| rd_b_data | output | 16 | Read port B value |
| wr_en | input | 1 | Write port enable |
| wr_byte | input | 1 | 1 = write low byte only, 0 = full word |
| wr_sel | input | 4 | Write port register index |
| wr_data | input | 16 | Write port data |
| sp_adj_en | input | 1 | Adjust register 15 by two |
| sp_adj_up | input | 1 | 1 = add 2, 0 = subtract 2 |
| dflt_wr_en | input | 1 | Load the default-register select |
| dflt_wr_sel | input | 4 | New default-register select |
| dflt_sel | output | 4 | Current default-register select |
| dflt_data | output | 16 | Value of the default register |
| lim_wr_en | input | 1 | Load the stack-limit register |
| lim_wr_data | input | 16 | New stack-limit value |
| lim_out | output | 16 | Current stack-limit value |
| sp_out | output | 16 | Current value of register 15 |

## Verification
Two pairs of events can land in the same cycle. The first is a stack adjustment together with a normal write aimed at register 15. The second is a read port and the write port addressing the same register. Directed steps set up both collisions, including byte writes and odd data aimed at register 15, a stack pointer that wraps below zero, and a simultaneous write to another register. A long random phase then biases the write index toward 15 and aims the read indices at the written entry. A behavioural model in the bench computes every output before each clock edge and compares all of them on every cycle.

// File: rtl/gpr_pkg.sv
// Package: shared sizes and reset constants for the working register bank.
// Assumes a 16-bit datapath in which stack entries are whole words.
package gpr_pkg;

    localparam int unsigned GPR_DATA_W = 16;
    localparam int unsigned GPR_NREG   = 16;
    localparam logic [15:0] GPR_SP_RST = 16'h0200;
    localparam int unsigned GPR_SP_STEP = 2;

    // Direction of a stack-pointer adjustment
    typedef enum logic {
        SP_DOWN = 1'b0,
        SP_UP   = 1'b1
    } sp_dir_e;

endpackage

// File: rtl/gpr_wr_decode.sv
// Module: gpr_wr_decode
// Turns the write index into per-entry enables. The stack entry's enable is
// suppressed while an adjustment is pending, because the adjustment wins.
// Assumes NREG is a power of two that matches SEL_W.
module gpr_wr_decode #(
    parameter int unsigned NREG   = 16,
    parameter int unsigned SP_IDX = NREG - 1,
    localparam int unsigned SEL_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             sp_adj_en,
    output logic [NREG-1:0]  we_vec
);

    // Build one enable per entry with a repeated compare
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        if (g == SP_IDX) begin : g_sp
            assign we_vec[g] = wr_en && (wr_sel == SEL_W'(g)) && !sp_adj_en;
        end else begin : g_plain
            assign we_vec[g] = wr_en && (wr_sel == SEL_W'(g));
        end
    end

    // R2: at most one entry is written per cycle
    p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));

    // R7: while an adjustment is pending the stack entry takes no normal write
    p_sp_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sp_adj_en |-> !we_vec[SP_IDX]);

endmodule

// File: rtl/gpr_entry.sv
// Module: gpr_entry
// One ordinary register with word and low-byte write and an optional bit 0
// that is held at zero. Also used for the stack-limit register.
// Assumes DATA_W is at least 16.
module gpr_entry #(
    parameter int unsigned DATA_W   = 16,
    parameter logic [DATA_W-1:0] RST_VAL = '0,
    parameter bit          LSB_ZERO = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              byte_only,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] next_val;

    // Keep the upper bits for a byte write
    always_comb begin
        merged = byte_only ? {q[DATA_W-1:8], wdata[7:0]} : wdata;
    end

    // Clear bit 0 when the entry must stay word-aligned
    if (LSB_ZERO) begin : g_align
        assign next_val = {merged[DATA_W-1:1], 1'b0};
    end else begin : g_free
        assign next_val = merged;
    end

    // Storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (we) begin
            q <= next_val;
        end
    end

    // R2: an entry that is not written keeps its value
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

    // R3: a byte write leaves the upper byte alone
    p_byte_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && byte_only) |=> (q[DATA_W-1:8] == $past(q[DATA_W-1:8])));

endmodule

// File: rtl/gpr_sp_entry.sv
// Module: gpr_sp_entry
// Stack-pointer entry. It is word-aligned, has its own reset value, and takes
// a plus/minus step adjustment that overrides a normal write.
// Assumes the decode has already masked the write enable during an adjustment.
module gpr_sp_entry #(
    parameter int unsigned DATA_W  = 16,
    parameter logic [DATA_W-1:0] RST_VAL = 16'h0200,
    parameter int unsigned STEP    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              byte_only,
    input  logic [DATA_W-1:0] wdata,
    input  logic              adj_en,
    input  gpr_pkg::sp_dir_e  adj_dir,
    output logic [DATA_W-1:0] q
);

    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] stepped;

    // Form the written value and the adjusted value
    always_comb begin
        merged  = byte_only ? {q[DATA_W-1:8], wdata[7:0]} : wdata;
        stepped = (adj_dir == gpr_pkg::SP_UP) ? q + STEP_V : q - STEP_V;
    end

    // The adjustment has priority over the normal write; bit 0 is always cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (adj_en) begin
            q <= {stepped[DATA_W-1:1], 1'b0};
        end else if (we) begin
            q <= {merged[DATA_W-1:1], 1'b0};
        end
    end

    // R6: an adjustment moves the pointer by exactly one step
    p_sp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adj_en |=> (q == ($past(adj_dir) == gpr_pkg::SP_UP ?
                          $past(q) + STEP_V : $past(q) - STEP_V)));

    // R5: with no adjustment and no write the pointer is stable
    p_sp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adj_en && !we) |=> $stable(q));

endmodule

// File: rtl/gpr_read_port.sv
// Module: gpr_read_port
// Combinational read of one entry from the flattened register array.
// Assumes sel is always inside the array, which holds when NREG = 2**SEL_W.
module gpr_read_port #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned NREG   = 16,
    localparam int unsigned SEL_W = $clog2(NREG)
) (
    input  logic [NREG-1:0][DATA_W-1:0] regs,
    input  logic [SEL_W-1:0]            sel,
    output logic [DATA_W-1:0]           data
);

    // Select one entry
    always_comb begin
        data = regs[sel];
    end

endmodule

// File: rtl/gpr_bank.sv
// Module: gpr_bank
// Working register bank: sixteen entries, two read ports, one write port with
// a byte mode, a stack-pointer entry with adjust, a default-operand select and
// a stack-limit register. Assumes a single clock and synchronous reset.
module gpr_bank #(
    parameter int unsigned DATA_W = gpr_pkg::GPR_DATA_W,
    parameter int unsigned NREG   = gpr_pkg::GPR_NREG,
    localparam int unsigned SEL_W = $clog2(NREG),
    localparam int unsigned SP_IDX = NREG - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic              wr_byte,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sp_adj_en,
    input  logic              sp_adj_up,
    input  logic              dflt_wr_en,
    input  logic [SEL_W-1:0]  dflt_wr_sel,
    output logic [SEL_W-1:0]  dflt_sel,
    output logic [DATA_W-1:0] dflt_data,
    input  logic              lim_wr_en,
    input  logic [DATA_W-1:0] lim_wr_data,
    output logic [DATA_W-1:0] lim_out,
    output logic [DATA_W-1:0] sp_out
);

    logic [NREG-1:0]             we_vec;
    logic [NREG-1:0][DATA_W-1:0] regs;
    gpr_pkg::sp_dir_e            adj_dir;

    assign adj_dir = sp_adj_up ? gpr_pkg::SP_UP : gpr_pkg::SP_DOWN;

    // Per-entry write enables
    gpr_wr_decode #(.NREG(NREG), .SP_IDX(SP_IDX)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .sp_adj_en (sp_adj_en),
        .we_vec    (we_vec)
    );

    // Storage: ordinary entries plus the stack entry at the top index
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == SP_IDX) begin : g_sp
            gpr_sp_entry #(
                .DATA_W  (DATA_W),
                .RST_VAL (DATA_W'(gpr_pkg::GPR_SP_RST)),
                .STEP    (gpr_pkg::GPR_SP_STEP)
            ) u_sp (
                .clk       (clk),
                .rst_n     (rst_n),
                .we        (we_vec[g]),
                .byte_only (wr_byte),
                .wdata     (wr_data),
                .adj_en    (sp_adj_en),
                .adj_dir   (adj_dir),
                .q         (regs[g])
            );
        end else begin : g_gp
            gpr_entry #(
                .DATA_W   (DATA_W),
                .RST_VAL  ('0),
                .LSB_ZERO (1'b0)
            ) u_gp (
                .clk       (clk),
                .rst_n     (rst_n),
                .we        (we_vec[g]),
                .byte_only (wr_byte),
                .wdata     (wr_data),
                .q         (regs[g])
            );
        end
    end

    // Stack-limit register: word writes only, bit 0 held at zero
    gpr_entry #(
        .DATA_W   (DATA_W),
        .RST_VAL  ('0),
        .LSB_ZERO (1'b1)
    ) u_lim (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (lim_wr_en),
        .byte_only (1'b0),
        .wdata     (lim_wr_data),
        .q         (lim_out)
    );

    // Default-operand select register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dflt_sel <= '0;
        end else if (dflt_wr_en) begin
            dflt_sel <= dflt_wr_sel;
        end
    end

    // Three read paths: two datapath ports and the default operand
    gpr_read_port #(.DATA_W(DATA_W), .NREG(NREG)) u_rd_a (
        .regs (regs), .sel (rd_a_sel), .data (rd_a_data)
    );
    gpr_read_port #(.DATA_W(DATA_W), .NREG(NREG)) u_rd_b (
        .regs (regs), .sel (rd_b_sel), .data (rd_b_data)
    );
    gpr_read_port #(.DATA_W(DATA_W), .NREG(NREG)) u_rd_d (
        .regs (regs), .sel (dflt_sel), .data (dflt_data)
    );

    assign sp_out = regs[SP_IDX];

    // R5: reading the stack entry never shows an odd value
    p_rd_sp_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == SEL_W'(SP_IDX)) |-> (rd_a_data[0] == 1'b0));

    // R9: the stack limit stays word-aligned
    p_lim_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lim_out[0] == 1'b0);

    // R9: the limit changes only on its own write
    p_lim_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lim_wr_en |=> $stable(lim_out));

    // R8: the default select takes the written index
    p_dflt_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_wr_en |=> (dflt_sel == $past(dflt_wr_sel)));

    // R10: port B on the stack index agrees with the stack output
    p_sp_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_sel == SEL_W'(SP_IDX)) |-> (rd_b_data == sp_out));

endmodule

// File: tb/test_gpr_bank.sv
// Bench for gpr_bank: a behavioural model is updated at every rising edge and
// all outputs are compared against it in the middle of every cycle.
module test_gpr_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_a_sel, rd_b_sel, wr_sel, dflt_wr_sel, dflt_sel;
    logic [15:0] rd_a_data, rd_b_data, wr_data, dflt_data, lim_wr_data, lim_out, sp_out;
    logic        wr_en, wr_byte, sp_adj_en, sp_adj_up, dflt_wr_en, lim_wr_en;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    logic [15:0] m_reg [16];
    logic [15:0] m_lim;
    logic [3:0]  m_dsel;

    always #4 clk = ~clk;

    gpr_bank i_gpr_bank (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_sel(wr_sel), .wr_data(wr_data),
        .sp_adj_en(sp_adj_en), .sp_adj_up(sp_adj_up),
        .dflt_wr_en(dflt_wr_en), .dflt_wr_sel(dflt_wr_sel),
        .dflt_sel(dflt_sel), .dflt_data(dflt_data),
        .lim_wr_en(lim_wr_en), .lim_wr_data(lim_wr_data), .lim_out(lim_out),
        .sp_out(sp_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_reg[i] = 16'h0000;
        m_reg[15] = 16'h0200;
        m_lim = 16'h0000;
        m_dsel = 4'd0;
    endtask

    // Model update at a rising edge, from the inputs held in this cycle
    task automatic model_edge();
        logic [15:0] v;
        if (!rst_n) begin
            model_reset();
            return;
        end
        if (wr_en && !(wr_sel == 4'd15 && sp_adj_en)) begin
            v = wr_byte ? {m_reg[wr_sel][15:8], wr_data[7:0]} : wr_data;
            if (wr_sel == 4'd15) v[0] = 1'b0;
            m_reg[wr_sel] = v;
        end
        if (sp_adj_en)
            m_reg[15] = sp_adj_up ? m_reg[15] + 16'd2 : m_reg[15] - 16'd2;
        if (lim_wr_en) m_lim = {lim_wr_data[15:1], 1'b0};
        if (dflt_wr_en) m_dsel = dflt_wr_sel;
    endtask

    // Compare every output against the model (pre-edge values: R4)
    task automatic compare(input string req);
        chk(req, "rd_a", rd_a_data, m_reg[rd_a_sel]);
        chk(req, "rd_b", rd_b_data, m_reg[rd_b_sel]);
        chk(req, "dflt_sel", {12'h0, dflt_sel}, {12'h0, m_dsel});
        chk(req, "dflt_data", dflt_data, m_reg[m_dsel]);
        chk(req, "lim_out", lim_out, m_lim);
        chk(req, "sp_out", sp_out, m_reg[15]);
    endtask

    task automatic idle();
        wr_en = 0; wr_byte = 0; wr_sel = 0; wr_data = 0;
        sp_adj_en = 0; sp_adj_up = 0; dflt_wr_en = 0; dflt_wr_sel = 0;
        lim_wr_en = 0; lim_wr_data = 0;
    endtask

    // One cycle: inputs already driven after a falling edge; check, then edge
    task automatic cycle(input string req);
        #1;
        if (rst_n) compare(req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] s, input logic [15:0] d, input logic b,
                      input logic [3:0] ra, input logic [3:0] rb, input string req);
        idle();
        wr_en = 1; wr_sel = s; wr_data = d; wr_byte = b;
        rd_a_sel = ra; rd_b_sel = rb;
        cycle(req);
    endtask

    task automatic look(input logic [3:0] ra, input logic [3:0] rb, input string req);
        idle();
        rd_a_sel = ra; rd_b_sel = rb;
        cycle(req);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        idle();
        rd_a_sel = 0; rd_b_sel = 0;
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset values of every register, select and limit
        for (int i = 0; i < 16; i += 2) look(4'(i), 4'(i + 1), "R1");
        chk("R1", "sp reset", sp_out, 16'h0200);

        // R2: word writes, seen on both ports next cycle
        for (int i = 0; i < 15; i++) wr(4'(i), 16'hA500 + 16'(i * 17), 0, 4'(i), 4'(i), "R2");
        for (int i = 0; i < 16; i++) look(4'(i), 4'(15 - i), "R2");

        // R3: byte write changes only the low byte
        wr(4'd3, 16'hFF5A, 1, 4'd3, 4'd0, "R3");
        look(4'd3, 4'd3, "R3");
        chk("R3", "r3 value", rd_a_data, {8'hA5, 8'h5A});

        // R4: read of the register being written returns the old value
        wr(4'd7, 16'h1234, 0, 4'd7, 4'd7, "R4");
        look(4'd7, 4'd7, "R4");

        // R5: odd values into register 15, word and byte
        wr(4'd15, 16'h3457, 0, 4'd15, 4'd15, "R5");
        look(4'd15, 4'd15, "R5");
        chk("R5", "sp lsb word", sp_out, 16'h3456);
        wr(4'd15, 16'h00FF, 1, 4'd15, 4'd15, "R5");
        look(4'd15, 4'd15, "R5");
        chk("R5", "sp lsb byte", sp_out, 16'h34FE);

        // R6: step down through zero and back up
        wr(4'd15, 16'h0002, 0, 4'd15, 4'd15, "R6");
        for (int i = 0; i < 3; i++) begin
            idle(); sp_adj_en = 1; sp_adj_up = 0; cycle("R6");
        end
        chk("R6", "sp wrap", sp_out, 16'hFFFC);
        for (int i = 0; i < 3; i++) begin
            idle(); sp_adj_en = 1; sp_adj_up = 1; cycle("R6");
        end
        chk("R6", "sp back", sp_out, 16'h0002);

        // R7: adjust beats a write to 15; a write elsewhere still lands
        idle(); sp_adj_en = 1; sp_adj_up = 1; wr_en = 1; wr_sel = 15; wr_data = 16'h7000;
        cycle("R7");
        chk("R7", "sp priority", sp_out, 16'h0004);
        idle(); sp_adj_en = 1; sp_adj_up = 0; wr_en = 1; wr_sel = 14; wr_data = 16'hBEEF;
        rd_a_sel = 14; cycle("R7");
        look(4'd14, 4'd15, "R7");
        chk("R7", "fp written", rd_a_data, 16'hBEEF);
        chk("R7", "sp stepped", rd_b_data, 16'h0002);

        // R8: default select follows writes
        for (int i = 0; i < 16; i += 5) begin
            idle(); dflt_wr_en = 1; dflt_wr_sel = 4'(i); cycle("R8");
            look(4'(i), 4'(i), "R8");
            chk("R8", "dflt data", dflt_data, rd_a_data);
        end

        // R9: limit is word-aligned and untouched by other writes
        idle(); lim_wr_en = 1; lim_wr_data = 16'h0F13; cycle("R9");
        wr(4'd15, 16'h0800, 0, 4'd15, 4'd0, "R9");
        idle(); sp_adj_en = 1; cycle("R9");
        chk("R9", "limit", lim_out, 16'h0F12);

        // R10 with all others: random traffic biased toward collisions
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            idle();
            wr_en       = r[0] | r[1];
            wr_byte     = r[2];
            wr_sel      = r[3] ? 4'd15 : 4'(r[7:4]);
            wr_data     = 16'($urandom);
            sp_adj_en   = r[8] & r[9];
            sp_adj_up   = r[10];
            dflt_wr_en  = (r[15:11] == 5'd0);
            dflt_wr_sel = 4'(r[19:16]);
            lim_wr_en   = (r[24:20] == 5'd1);
            lim_wr_data = 16'($urandom);
            rd_a_sel    = r[25] ? wr_sel : 4'(r[29:26]);
            rd_b_sel    = r[30] ? 4'd15 : 4'($urandom);
            cycle("R10");
        end

        // R1: reset in the middle of traffic
        idle(); rst_n = 0; cycle("R1");
        rst_n = 1;
        for (int i = 0; i < 16; i += 2) look(4'(i), 4'(i + 1), "R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule